// File: doc/BRIEF.md
# Timestamp-Ordered Resequencing Multiplexor

This block is the output stage of a switch that spreads cells over several slower parallel layers. Each layer delivers cells to the block over its own slow link, and each cell carries the slot in which it first arrived at the switch. The block keeps a small queue per layer. It then puts the cells back onto a single line-rate output in first-come-first-served order of those arrival slots. A cell that turns up before an older cell still travelling on another layer is held until its turn comes.

A chip-wide slot counter is supplied on `cur_slot`, and every stamp is compared against it modulo 2^SLOT_W. A queue head may leave only once its age has reached the reorder hold latency. Among the heads that are old enough, the oldest stamp leaves first. At most one cell leaves per slot. Cells that arrive at a queue already holding its full depth are dropped and reported on a per-layer flag.

Top module: `resq_mux`

## Requirements
- R1: While reset is high, and in the first cycle after it, `out_valid` is 0 and every bit of `ovf` is 0.
- R2: Each layer has its own queue of FIFO_DEPTH cells (default 4). Cells from one layer are kept in the order in which that layer delivered them.
- R3: The age of a head cell is (cur_slot − stamp) mod 2^SLOT_W. A head can be chosen in a cycle only if this age is at least HOLD_LAT (default 8). The chosen cell appears on `out_valid`/`out_data`/`out_ts` in the following cycle.
- R4: Among the heads that are old enough, the one with the oldest stamp is chosen. Stamp a is older than stamp b when bit SLOT_W−1 of (a − b) mod 2^SLOT_W is 1.
- R5: When several old-enough heads carry equal stamps, the layer with the lowest index is chosen.
- R6: At most one cell leaves per cycle. The output carries that cell's payload and its stamp unchanged.
- R7: If a layer delivers a cell while its queue is full and that same queue is not popped in the same cycle, the cell is discarded and bit `ovf[layer]` is 1 in the next cycle. A full queue that is popped in the same cycle accepts the new cell.
- R8: Ordering and eligibility stay correct when the slot counter and the stamps wrap past 2^SLOT_W−1, provided every age stays below 2^(SLOT_W−1).
- R9: Every accepted cell leaves exactly once. Nothing is lost or duplicated, and a queue is never popped while empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_slot | input | SLOT_W | Current slot number, wraps |
| in_valid | input | LAYERS | Cell present from each layer this cycle |
| in_data | input | LAYERS*PAY_W | Payloads, layer g at bits g*PAY_W upward |
| in_ts | input | LAYERS*SLOT_W | Arrival stamps, layer g at bits g*SLOT_W upward |
| out_valid | output | 1 | A cell is on the output this cycle |
| out_data | output | PAY_W | Payload of the output cell |
| out_ts | output | SLOT_W | Arrival stamp of the output cell |
| ovf | output | LAYERS | One-cycle drop flag per layer |

## Verification
The bench targets four corner cases.
- All four layers deliver the same stamp in one slot. A picker that broke ties wrongly would release them in some order other than layer 0 to 3.
- Cells with mixed in-flight delays are sent across two wraps of the slot counter. A plain magnitude compare would then release fresh cells ahead of older ones, or hold cells far too long.
- One layer is overfilled past its depth. A design that overwrote or took the extra cell would emit an unexpected payload, or raise no flag.
- Held cells are sent in ahead of older in-flight ones. A design that ignored the hold latency would let them overtake, and the order check would report it.

// File: rtl/resq_pkg.sv
package resq_pkg;
    localparam int SLOT_W = 8;
    localparam int PAY_W  = 16;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic [PAY_W-1:0] payload;
        slot_t            stamp;
    } cell_t;

    // elapsed slots from stamp to now, modulo the counter width
    function automatic slot_t slot_age(slot_t now, slot_t ts);
        return now - ts;
    endfunction

    // a was stamped strictly before b (window of half the counter range)
    function automatic logic slot_before(slot_t a, slot_t b);
        slot_t d;
        d = a - b;
        return d[SLOT_W-1];
    endfunction
endpackage

// File: rtl/resq_fifo.sv
module resq_fifo
    import resq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  cell_t wr_cell,
    input  logic  rd_en,
    output cell_t head,
    output logic  nonempty,
    output logic  full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    cell_t         mem [DEPTH];
    logic [PW-1:0] rp, wp;
    logic [CW-1:0] cnt;
    logic          do_rd, do_wr;

    assign do_rd = rd_en && (cnt != '0);
    assign do_wr = wr_en && ((cnt != CAP) || do_rd);

    always_ff @(posedge clk) begin
        if (rst) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == LAST) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_wr) - CW'(do_rd);
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_cell;
    end

    assign head     = mem[rp];
    assign nonempty = (cnt != '0);
    assign full     = (cnt == CAP);

    AST_WITHIN_CAP: assert property (@(posedge clk) disable iff (rst)
        cnt <= CAP);                                               // R2
    AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (cnt != '0));                                     // R9
endmodule

// File: rtl/resq_pick.sv
module resq_pick
    import resq_pkg::*;
#(
    parameter int LAYERS = 4
) (
    input  logic [LAYERS-1:0] ready,
    input  slot_t             stamps [LAYERS],
    output logic [LAYERS-1:0] grant,
    output logic              any
);
    slot_t best;

    // strict comparison keeps the lowest index on equal stamps
    always_comb begin
        grant = '0;
        any   = 1'b0;
        best  = '0;
        for (int i = 0; i < LAYERS; i++) begin
            if (ready[i] && (!any || slot_before(stamps[i], best))) begin
                grant    = '0;
                grant[i] = 1'b1;
                any      = 1'b1;
                best     = stamps[i];
            end
        end
    end
endmodule

// File: rtl/resq_mux.sv
module resq_mux
    import resq_pkg::*;
#(
    parameter int LAYERS     = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int HOLD_LAT   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SLOT_W-1:0]        cur_slot,
    input  logic [LAYERS-1:0]        in_valid,
    input  logic [LAYERS*PAY_W-1:0]  in_data,
    input  logic [LAYERS*SLOT_W-1:0] in_ts,
    output logic                     out_valid,
    output logic [PAY_W-1:0]         out_data,
    output logic [SLOT_W-1:0]        out_ts,
    output logic [LAYERS-1:0]        ovf
);
    localparam slot_t HOLD_V = SLOT_W'(HOLD_LAT);

    cell_t             heads  [LAYERS];
    slot_t             stamps [LAYERS];
    logic [LAYERS-1:0] nonempty, full, ready, grant, drop;
    logic              any;
    cell_t             sel;

    for (genvar g = 0; g < LAYERS; g++) begin : g_lane
        localparam logic [LAYERS-1:0] LOWER = LAYERS'((1 << g) - 1);
        cell_t incell;

        assign incell.payload = in_data[g*PAY_W +: PAY_W];
        assign incell.stamp   = in_ts[g*SLOT_W +: SLOT_W];

        resq_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (in_valid[g]),
            .wr_cell  (incell),
            .rd_en    (grant[g]),
            .head     (heads[g]),
            .nonempty (nonempty[g]),
            .full     (full[g])
        );

        assign stamps[g] = heads[g].stamp;
        assign ready[g]  = nonempty[g] && (slot_age(cur_slot, heads[g].stamp) >= HOLD_V);
        assign drop[g]   = in_valid[g] && full[g] && !grant[g];

        AST_OLDEST_WINS: assert property (@(posedge clk) disable iff (rst)
            (any && ready[g]) |-> !slot_before(stamps[g], sel.stamp));             // R4
        AST_TIE_LOW_INDEX: assert property (@(posedge clk) disable iff (rst)
            (any && ready[g] && stamps[g] == sel.stamp) |-> (grant[g] || (grant & LOWER) != '0)); // R5
        AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
            ovf[g] |-> $past(in_valid[g] && !grant[g]));                            // R7
    end

    resq_pick #(.LAYERS(LAYERS)) u_pick (
        .ready  (ready),
        .stamps (stamps),
        .grant  (grant),
        .any    (any)
    );

    always_comb begin
        sel = '0;
        for (int i = 0; i < LAYERS; i++) begin
            if (grant[i]) sel = heads[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ts    <= '0;
            ovf       <= '0;
        end else begin
            out_valid <= any;
            ovf       <= drop;
            if (any) begin
                out_data <= sel.payload;
                out_ts   <= sel.stamp;
            end
        end
    end

    AST_RELEASE_AGED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (slot_age($past(cur_slot), out_ts) >= HOLD_V));              // R3
    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $countones(grant) <= 1);                                                    // R6
endmodule

// File: tb/resq_mux_bench.sv
module resq_mux_bench;
    import resq_pkg::*;

    localparam int CLK_NS = 10;
    localparam int K      = 4;
    localparam int DEP    = 4;
    localparam int HOLD   = 8;
    localparam int POOL   = 64;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [SLOT_W-1:0]   cur_slot = '0;
    logic [K-1:0]        in_valid = '0;
    logic [K*PAY_W-1:0]  in_data  = '0;
    logic [K*SLOT_W-1:0] in_ts    = '0;
    logic                out_valid;
    logic [PAY_W-1:0]    out_data;
    logic [SLOT_W-1:0]   out_ts;
    logic [K-1:0]        ovf;

    resq_mux #(.LAYERS(K), .FIFO_DEPTH(DEP), .HOLD_LAT(HOLD)) u_resq_mux (
        .clk(clk), .rst(rst), .cur_slot(cur_slot), .in_valid(in_valid),
        .in_data(in_data), .in_ts(in_ts), .out_valid(out_valid),
        .out_data(out_data), .out_ts(out_ts), .ovf(ovf)
    );

    always #(CLK_NS/2) clk = ~clk;

    // reference pool of accepted, not yet emitted cells
    bit               p_v  [POOL];
    int               p_l  [POOL];
    logic [7:0]       p_ts [POOL];
    logic [PAY_W-1:0] p_d  [POOL];

    int checks = 0, fails = 0, tick = 0, seq = 0;
    int accepted = 0, emitted = 0;
    bit done = 1'b0;
    logic             exp_v = 1'b0;
    logic [PAY_W-1:0] exp_d = '0;
    logic [7:0]       exp_ts = '0;
    logic [K-1:0]     exp_ovf = '0;
    logic [15:0]      lfsr = 16'hACE1;
    int               last_send [K];
    logic [K-1:0]     nv;
    logic [7:0]       nts [K];

    function automatic bit older(logic [7:0] a, logic [7:0] b);
        logic [7:0] d;
        d = a - b;
        return d[7];
    endfunction

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // one slot: compare last prediction, drive new inputs, predict, wait
    task automatic slot_step();
        int best, cnt_l;
        logic [7:0] age;
        logic [PAY_W-1:0] tag;
        checks++;
        if (out_valid !== exp_v || (exp_v && (out_data !== exp_d || out_ts !== exp_ts))) begin
            fails++;
            $display("FAIL R3 R4 R5 R6 R8 slot %0d: got v=%b d=%h ts=%0d, expected v=%b d=%h ts=%0d",
                     tick, out_valid, out_data, out_ts, exp_v, exp_d, exp_ts);
        end
        if (out_valid === 1'b1) emitted++;
        checks++;
        if (ovf !== exp_ovf) begin
            fails++;
            $display("FAIL R2 R7 slot %0d: ovf got %b expected %b", tick, ovf, exp_ovf);
        end
        tick++;
        cur_slot = tick[7:0];
        in_valid = '0;
        for (int l = 0; l < K; l++) begin
            tag = {l[1:0], seq[13:0]};
            seq++;
            in_valid[l] = nv[l];
            in_data[l*PAY_W +: PAY_W] = tag;
            in_ts[l*SLOT_W +: SLOT_W] = nts[l];
        end
        best = -1;
        for (int e = 0; e < POOL; e++) begin
            age = cur_slot - p_ts[e];
            if (p_v[e] && age >= 8'(HOLD)) begin
                if (best < 0 || older(p_ts[e], p_ts[best]) ||
                    (p_ts[e] == p_ts[best] && p_l[e] < p_l[best])) best = e;
            end
        end
        exp_v = (best >= 0);
        exp_ovf = '0;
        for (int l = 0; l < K; l++) begin
            if (nv[l]) begin
                cnt_l = 0;
                for (int e = 0; e < POOL; e++) if (p_v[e] && p_l[e] == l) cnt_l++;
                if (cnt_l == DEP && !(best >= 0 && p_l[best] == l)) begin
                    exp_ovf[l] = 1'b1;
                end else begin
                    for (int e = 0; e < POOL; e++) begin
                        if (!p_v[e] && e != best) begin
                            p_v[e] = 1'b1; p_l[e] = l; p_ts[e] = nts[l];
                            p_d[e] = in_data[l*PAY_W +: PAY_W];
                            accepted++;
                            break;
                        end
                    end
                end
            end
        end
        if (best >= 0) begin
            exp_d = p_d[best];
            exp_ts = p_ts[best];
            p_v[best] = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            nv = '0;
            slot_step();
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired at slot %0d", tick);
            report();
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < POOL; e++) begin p_v[e] = 1'b0; p_l[e] = 0; p_ts[e] = '0; p_d[e] = '0; end
        for (int l = 0; l < K; l++) begin last_send[l] = -100; nts[l] = '0; end
        nv = '0;
        repeat (3) @(negedge clk);
        checks++;   // R1 during reset
        if (out_valid !== 1'b0 || ovf !== '0) begin
            fails++;
            $display("FAIL R1 reset: got v=%b ovf=%b expected v=0 ovf=0", out_valid, ovf);
        end
        rst = 1'b0;
        @(negedge clk);
        // R1 first cycle after reset is compared inside slot_step with exp_v=0

        // random traffic across two counter wraps (R3 R4 R8), per-layer gap of K slots
        for (int c = 0; c < 600; c++) begin
            for (int l = 0; l < K; l++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                nv[l] = 1'b0;
                if ((tick + 1 - last_send[l]) >= K && lfsr[0]) begin
                    nv[l] = 1'b1;
                    last_send[l] = tick + 1;
                    nts[l] = 8'(tick + 1 - int'(lfsr[3:2]));
                end
            end
            slot_step();
        end
        idle(30);

        // R5: all layers deliver an identical stamp in one slot
        for (int l = 0; l < K; l++) begin nv[l] = 1'b1; nts[l] = 8'(tick); end
        slot_step();
        idle(30);

        // R2 R7: layer 2 is overfilled with five cells while none is old enough
        for (int i = 0; i < 5; i++) begin
            nv = 4'b0100;
            nts[2] = 8'(tick + 1);
            slot_step();
        end
        idle(30);

        // R9: every accepted cell was emitted exactly once
        checks++;
        if (emitted != accepted) begin
            fails++;
            $display("FAIL R9 emitted %0d cells, expected %0d", emitted, accepted);
        end
        done = 1'b1;
        report();
        $finish;
    end
endmodule